// File: doc/BRIEF.md
# Time-Multiplexed 20-Tap FIR Filter

This block is a finite impulse response filter with twenty signed taps. It does the work with four multiply-add stages that it reuses on every clock. Input samples arrive at one fifth of the clock rate. Each stage holds five of the coefficients and a five-deep window of the sample history. In each of the five cycles of a sample period, every stage multiplies one stored sample by one coefficient. It adds that product to the running partial sum handed on by the stage before it. After the last stage, an accumulator adds up the five partial sums that belong to one output sample.

The stages run one cycle apart, so each stage reads the same local address one cycle after its upstream neighbour. That keeps the partial sum in step as it moves along the chain. The accumulator starts each new result by loading the incoming partial sum instead of adding it to the old total. In that same cycle, the finished total is copied to the output register. Coefficients are written one at a time through a preload port while the filter is idle.

Top module: `sp_fir`

## Requirements
- R1: Each result equals the sum over j = 0..19 of h[j]·x[n−j], as a full-precision signed 48-bit value. Here x[n] is the sample that result belongs to, h[0] multiplies the newest sample, and samples before the first one after reset count as zero.
- R2: A sample is taken in every cycle where `in_valid` is high. Within a burst, strobes come exactly 5 cycles apart. A new burst may start any number of cycles, 5 or more, after the previous strobe, and a strobe is never given sooner.
- R3: The result for a sample taken in cycle t is presented in cycle t+13, with `out_valid` high for exactly one cycle.
- R4: A result is produced only for a sample whose next strobe follows exactly 5 cycles later. The last sample of a burst yields no output, and `out_valid` is low in every other cycle.
- R5: A write with `coef_we` high and `coef_addr` = j, for j from 0 to 19, sets h[j] to `coef_data` for later samples. Writes with `coef_addr` from 20 to 31 change nothing.
- R6: The sample history is kept across idle gaps between bursts, and only reset clears it.
- R7: Reset clears the history and all coefficients to zero, and drives `out_valid` low and `out_data` to zero.
- R8: Each result contains only its own five partial sums. Its accumulation starts with a reload, in the same cycle that the previous total is captured on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 18 | Signed input sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 5 | Tap index to write |
| coef_data | input | 18 | Signed coefficient value |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 48 | Signed filter result |

## Verification
The bench aims at the seams between stages and between sample periods.

A fault in how samples pass from one stage's window into the next would show up in the impulse response as a duplicated or missing tap. A reload that misses its cycle would carry the previous total into the next result, and the alternating full-scale run exposes that at once. Irregular gaps and a long idle check two things. Results for samples at the end of a burst must be withheld, and the history must survive the gap. Writes above tap 19 must leave every later output unchanged.

// File: rtl/sfir_pkg.sv
package sfir_pkg;

   // Phase marker carried down the control pipeline with each partial sum.
   typedef struct packed {
      logic act;    // a sample period is in progress
      logic first;  // phase 0 of the period
      logic last;   // final phase of the period
   } slot_t;

   // Accumulator operation chosen per cycle.
   typedef enum logic {
      ACC_ADD  = 1'b0,
      ACC_LOAD = 1'b1
   } acc_op_e;

endpackage

// File: rtl/sp_fir_seq.sv
module sp_fir_seq
   import sfir_pkg::*;
#(
   parameter  int PHASES = 5,
   parameter  int NSTAGE = 4,
   localparam int AW     = (PHASES > 1) ? $clog2(PHASES) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          tap_act   [NSTAGE],
   output logic [AW-1:0] tap_addr  [NSTAGE],
   output logic          tap_shift [NSTAGE],
   output slot_t         acc_slot
);

   localparam int            LINE    = NSTAGE + 2;
   localparam logic [AW-1:0] LAST_PH = AW'(PHASES - 1);

   logic [AW-1:0] cnt;
   logic          busy;
   slot_t         slot0;
   slot_t         slot_q  [1:LINE];
   logic [AW-1:0] addr_q  [1:NSTAGE-1];
   logic          shift_q [1:NSTAGE-1];

   // Phase counter: restarted by each strobe, falls idle after one period.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         busy <= 1'b0;
      end else if (in_valid) begin
         cnt  <= '0;
         busy <= 1'b1;
      end else if (busy) begin
         if (cnt == LAST_PH) busy <= 1'b0;
         else                cnt  <= cnt + 1'b1;
      end
   end

   always_comb begin
      slot0.act   = busy;
      slot0.first = busy && (cnt == '0);
      slot0.last  = busy && (cnt == LAST_PH);
   end

   // Skew line: stage s sees the stage-0 control s cycles late.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 1; i <= LINE; i++) slot_q[i] <= '0;
         for (int i = 1; i < NSTAGE; i++) begin
            addr_q[i]  <= '0;
            shift_q[i] <= 1'b0;
         end
      end else begin
         slot_q[1]  <= slot0;
         addr_q[1]  <= cnt;
         shift_q[1] <= in_valid;
         for (int i = 2; i <= LINE; i++) slot_q[i] <= slot_q[i-1];
         for (int i = 2; i < NSTAGE; i++) begin
            addr_q[i]  <= addr_q[i-1];
            shift_q[i] <= shift_q[i-1];
         end
      end
   end

   for (genvar s = 0; s < NSTAGE; s++) begin : g_tap_ctl
      if (s == 0) begin : g_head
         assign tap_act[s]   = slot0.act;
         assign tap_addr[s]  = cnt;
         assign tap_shift[s] = in_valid;
      end else begin : g_tail
         assign tap_act[s]   = slot_q[s].act;
         assign tap_addr[s]  = addr_q[s];
         assign tap_shift[s] = shift_q[s];
      end
   end

   assign acc_slot = slot_q[LINE];

   // R2: a strobe may only land on the last phase or while idle
   assert_strobe_period_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (!busy || cnt == LAST_PH));

   // R2: phase counter never leaves the period
   assert_phase_bound_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt <= LAST_PH));

endmodule

// File: rtl/sp_fir_tap.sv
module sp_fir_tap #(
   parameter  int DATA_W = 18,
   parameter  int COEF_W = 18,
   parameter  int ACC_W  = 48,
   parameter  int PHASES = 5,
   parameter  int CA_W   = 5,
   parameter  int BASE   = 0,
   localparam int AW     = (PHASES > 1) ? $clog2(PHASES) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     shift_en,
   input  logic signed [DATA_W-1:0] shift_in,
   output logic signed [DATA_W-1:0] shift_out,
   input  logic                     rd_act,
   input  logic        [AW-1:0]     rd_addr,
   input  logic                     coef_we,
   input  logic        [CA_W-1:0]   coef_addr,
   input  logic signed [COEF_W-1:0] coef_data,
   input  logic signed [ACC_W-1:0]  cas_in,
   output logic signed [ACC_W-1:0]  cas_out
);

   localparam int PROD_W = DATA_W + COEF_W;
   localparam int EXT    = ACC_W - PROD_W;

   // Window of PHASES samples plus one spill slot handed to the next stage.
   logic signed [DATA_W-1:0] win  [PHASES+1];
   logic signed [COEF_W-1:0] cmem [PHASES];
   logic signed [DATA_W-1:0] op_a;
   logic signed [COEF_W-1:0] op_b;
   logic signed [PROD_W-1:0] prod;
   logic signed [ACC_W-1:0]  cas_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i <= PHASES; i++) win[i] <= '0;
      end else if (shift_en) begin
         win[0] <= shift_in;
         for (int i = 1; i <= PHASES; i++) win[i] <= win[i-1];
      end
   end

   assign shift_out = win[PHASES];

   // Local coefficient bank answers only to its own tap indices.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < PHASES; k++) cmem[k] <= '0;
      end else if (coef_we) begin
         for (int k = 0; k < PHASES; k++)
            if (coef_addr == CA_W'(BASE + k)) cmem[k] <= coef_data;
      end
   end

   // Operand, product and chain registers.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_a  <= '0;
         op_b  <= '0;
         prod  <= '0;
         cas_q <= '0;
      end else begin
         op_a  <= rd_act ? win[rd_addr]  : '0;
         op_b  <= rd_act ? cmem[rd_addr] : '0;
         prod  <= op_a * op_b;
         cas_q <= cas_in + $signed({{EXT{prod[PROD_W-1]}}, prod});
      end
   end

   assign cas_out = cas_q;

   // R1: reads stay inside the local window
   assert_addr_range_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      rd_act |-> (rd_addr <= AW'(PHASES - 1)));

endmodule

// File: rtl/sp_fir_acc.sv
module sp_fir_acc
   import sfir_pkg::*;
#(
   parameter int ACC_W = 48
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  slot_t                   slot,
   input  logic signed [ACC_W-1:0] chain_in,
   output logic                    out_valid,
   output logic signed [ACC_W-1:0] out_data
);

   logic signed [ACC_W-1:0] acc;
   logic                    primed;
   acc_op_e                 op;
   logic                    capture;

   assign op      = slot.first ? ACC_LOAD : ACC_ADD;
   assign capture = slot.act && slot.first && primed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc <= '0;
      end else if (slot.act) begin
         acc <= (op == ACC_LOAD) ? chain_in : acc + chain_in;
      end
   end

   // Total is complete once the final phase has been added, and stays valid
   // only while the next period follows directly.
   always_ff @(posedge clk) begin
      if (!rst_n)          primed <= 1'b0;
      else if (!slot.act)  primed <= 1'b0;
      else if (slot.last)  primed <= 1'b1;
      else if (slot.first) primed <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= capture;
         if (capture) out_data <= acc;
      end
   end

   // R8: output capture coincides with an accumulator reload
   assert_capture_on_reload_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(slot.act && slot.first));

   // R3: result strobe lasts a single cycle
   assert_single_pulse_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

endmodule

// File: rtl/sp_fir.sv
module sp_fir
   import sfir_pkg::*;
#(
   parameter  int NUM_TAPS   = 20,
   parameter  int NUM_STAGES = 4,
   parameter  int DATA_W     = 18,
   parameter  int COEF_W     = 18,
   parameter  int ACC_W      = 48,
   localparam int CA_W       = $clog2(NUM_TAPS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_data,
   input  logic                     coef_we,
   input  logic        [CA_W-1:0]   coef_addr,
   input  logic signed [COEF_W-1:0] coef_data,
   output logic                     out_valid,
   output logic signed [ACC_W-1:0]  out_data
);

   localparam int PHASES = NUM_TAPS / NUM_STAGES;
   localparam int AW     = (PHASES > 1) ? $clog2(PHASES) : 1;

   // Elaboration-time parameter checks.
   if (NUM_TAPS % NUM_STAGES != 0) begin : g_chk_div
      $error("tap count must be a multiple of the stage count");
   end
   if (PHASES < 2) begin : g_chk_phases
      $error("at least two phases per sample period are required");
   end
   if (NUM_STAGES < 2) begin : g_chk_stages
      $error("at least two stages are required");
   end
   if (ACC_W < DATA_W + COEF_W + $clog2(NUM_TAPS)) begin : g_chk_acc
      $error("accumulator too narrow for the full tap sum");
   end

   logic                     tap_act   [NUM_STAGES];
   logic [AW-1:0]            tap_addr  [NUM_STAGES];
   logic                     tap_shift [NUM_STAGES];
   slot_t                    acc_slot;
   logic signed [DATA_W-1:0] spill     [NUM_STAGES];
   logic signed [ACC_W-1:0]  cas       [NUM_STAGES+1];

   sp_fir_seq #(
      .PHASES (PHASES),
      .NSTAGE (NUM_STAGES)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .tap_act   (tap_act),
      .tap_addr  (tap_addr),
      .tap_shift (tap_shift),
      .acc_slot  (acc_slot)
   );

   assign cas[0] = '0;

   for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
      logic signed [DATA_W-1:0] feed;
      if (s == 0) begin : g_src_in
         assign feed = in_data;
      end else begin : g_src_prev
         assign feed = spill[s-1];
      end

      sp_fir_tap #(
         .DATA_W (DATA_W),
         .COEF_W (COEF_W),
         .ACC_W  (ACC_W),
         .PHASES (PHASES),
         .CA_W   (CA_W),
         .BASE   (s * PHASES)
      ) u_tap (
         .clk       (clk),
         .rst_n     (rst_n),
         .shift_en  (tap_shift[s]),
         .shift_in  (feed),
         .shift_out (spill[s]),
         .rd_act    (tap_act[s]),
         .rd_addr   (tap_addr[s]),
         .coef_we   (coef_we),
         .coef_addr (coef_addr),
         .coef_data (coef_data),
         .cas_in    (cas[s]),
         .cas_out   (cas[s+1])
      );
   end

   sp_fir_acc #(
      .ACC_W (ACC_W)
   ) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot      (acc_slot),
      .chain_in  (cas[NUM_STAGES]),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

endmodule

// File: tb/tb_sp_fir.sv
module tb_sp_fir;

   localparam int TAPS = 20;
   localparam int STG  = 4;
   localparam int PH   = TAPS / STG;
   localparam int LAT  = PH + STG + 4;
   localparam int MAXC = 4096;

   logic               clk = 1'b0;
   logic               rst_n;
   logic               in_valid;
   logic signed [17:0] in_data;
   logic               coef_we;
   logic [4:0]         coef_addr;
   logic signed [17:0] coef_data;
   logic               out_valid;
   logic signed [47:0] out_data;

   always #2 clk = ~clk;

   sp_fir dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .coef_we   (coef_we),
      .coef_addr (coef_addr),
      .coef_data (coef_data),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   int     n_chk = 0;
   int     n_bad = 0;
   int     cyc   = 0;
   bit     done  = 0;
   string  tag   = "R7";
   longint h  [TAPS];
   longint xh [TAPS];
   bit     exp_v [MAXC];
   longint exp_d [MAXC];
   int     prev_cyc  = -100;
   longint prev_y    = 0;
   bit     prev_pend = 0;

   // Advance to the next negative edge and compare against the model.
   task automatic tick();
      bit     ev;
      longint got;
      @(negedge clk);
      cyc++;
      ev = (cyc < MAXC) ? exp_v[cyc] : 1'b0;
      n_chk++;
      if (out_valid !== ev) begin
         n_bad++;
         $display("FAIL R3/R4 cycle %0d out_valid=%b expected %b", cyc, out_valid, ev);
      end else if (ev) begin
         n_chk++;
         got = longint'(out_data);
         if (got != exp_d[cyc]) begin
            n_bad++;
            $display("FAIL %s cycle %0d out_data=%0d expected %0d", tag, cyc, got, exp_d[cyc]);
         end
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic send(input longint x);
      longint y = 0;
      for (int j = TAPS - 1; j > 0; j--) xh[j] = xh[j-1];
      xh[0] = x;
      for (int j = 0; j < TAPS; j++) y += h[j] * xh[j];
      // The previous sample gets a result only when this strobe follows in step (R4).
      if (prev_pend && cyc == prev_cyc + PH && prev_cyc + LAT < MAXC) begin
         exp_v[prev_cyc + LAT] = 1'b1;
         exp_d[prev_cyc + LAT] = prev_y;
      end
      prev_cyc  = cyc;
      prev_y    = y;
      prev_pend = 1'b1;
      in_valid  = 1'b1;
      in_data   = x[17:0];
      tick();
      in_valid  = 1'b0;
   endtask

   task automatic burst_rand(input int n);
      for (int i = 0; i < n; i++) begin
         send(longint'(int'($urandom_range(0, 262143)) - 131072));
         idle(PH - 1);
      end
   endtask

   task automatic wr_coef(input int a, input longint v);
      coef_we   = 1'b1;
      coef_addr = a[4:0];
      coef_data = v[17:0];
      if (a < TAPS) h[a] = v;
      tick();
      coef_we = 1'b0;
   endtask

   initial begin
      for (int j = 0; j < TAPS; j++) begin
         h[j]  = 0;
         xh[j] = 0;
      end
      rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
      coef_we = 1'b0; coef_addr = '0; coef_data = '0;
      idle(4);
      // R7: reset state of the result port
      n_chk++;
      if (out_valid !== 1'b0 || out_data !== 48'sd0) begin
         n_bad++;
         $display("FAIL R7 reset out_valid=%b out_data=%0d expected 0 0", out_valid, out_data);
      end
      rst_n = 1'b1;

      // R7: cleared coefficients give zero results
      tag = "R7";
      burst_rand(6);
      idle(LAT + 2);

      // R5: preload distinct coefficients
      tag = "R5";
      for (int j = 0; j < TAPS; j++) wr_coef(j, longint'(j * 997 - 9000));
      idle(2);

      // R1: impulse then random burst
      tag = "R1";
      send(1);
      idle(PH - 1);
      for (int i = 0; i < TAPS + 2; i++) begin
         send(0);
         idle(PH - 1);
      end
      burst_rand(30);
      idle(LAT + 2);

      // R5: out-of-range writes must not disturb any tap
      tag = "R5";
      for (int a = TAPS; a < 32; a++) wr_coef(a, longint'(int'($urandom_range(1, 100000))));
      burst_rand(10);

      // R2: bursts separated by irregular gaps
      tag = "R2";
      begin
         int sp [10] = '{5, 5, 7, 5, 5, 11, 5, 6, 5, 5};
         for (int i = 0; i < 10; i++) begin
            send(longint'(int'($urandom_range(0, 262143)) - 131072));
            idle(sp[i] - 1);
         end
      end

      // R6: history survives a long idle gap
      tag = "R6";
      idle(40);
      burst_rand(8);
      idle(LAT + 2);

      // R8: full-scale values, then alternating extremes
      tag = "R8";
      for (int j = 0; j < TAPS; j++) wr_coef(j, -131072);
      idle(2);
      for (int i = 0; i < 25; i++) begin
         send(-131072);
         idle(PH - 1);
      end
      for (int i = 0; i < 20; i++) begin
         send((i % 2 == 0) ? 131071 : -131072);
         idle(PH - 1);
      end

      // R4: last sample of the burst yields nothing
      tag = "R4";
      idle(LAT + 10);

      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(4 * 20000);
      if (!done) begin
         n_bad++;
         $display("FAIL R3 watchdog expired at cycle %0d expected completion", cyc);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule